// File: doc/BRIEF.md
# Trap Entry Sequencer

This block computes, in one clock edge, every architectural state edit a register-windowed processor core makes when it takes a trap. The core hands it a trap request with its type code, a flag saying whether the trap comes from the current instruction (synchronous) or from an outside event (asynchronous), a flag marking a reset trap, and the live status fields, program counters and trap base register. The block returns the edited status fields, the rotated window pointer, the two return addresses to write into the first two local registers of the trap window, the merged trap base register and the redirected PC and nPC.

The status word is never copied whole. Only edits that software can undo are made: the trap-enable bit is cleared, the supervisor bit is copied into the previous-supervisor bit and the window pointer steps down by one with wrap-around. The interrupt level field passes through unchanged. A synchronous trap that arrives while traps are disabled cannot be vectored, so the block enters a sticky error mode instead.

The request side is a valid/ready handshake. `trap_ready` is high whenever the block is not in error mode. A request is consumed on any rising edge where `trap_valid` and `trap_ready` are both high. The core must hold the request and its operands stable until that edge. When `trap_ready` is low the request is held off indefinitely. All outputs are registered and change only on an accepted trap, so they hold their last values between traps.

Top module: `trap_entry_seq`

## Requirements
- R1: After `rst_n` is released, `trap_ready` is 1, `err_mode` and `lreg_wr` are 0, and every status, counter and register output is 0. A request is accepted only on an edge where `trap_valid` and `trap_ready` are both 1.
- R2: A trap is taken when an accepted request has `trap_is_reset`=1, or has `st_et`=1. In the cycle after the accepting edge, `lreg_wr` is 1 for exactly that one cycle and `new_et` is 0.
- R3: On a taken trap, `new_ps` equals the `st_s` value of the request.
- R4: On a taken trap, `new_cwp` is `st_cwp` minus one, and 0 wraps to NWIN-1 (7 with the default of 8 windows).
- R5: On a taken trap, `new_tbr` equals `cur_tbr` with bits [11:4] (the trap-type field) replaced by `trap_code`, and all other bits kept.
- R6: On a taken non-reset trap, `new_pc` equals `new_tbr` and `new_npc` equals `new_tbr`+4.
- R7: On a taken reset trap, `new_pc` is 0 and `new_npc` is 4, even when `st_et` is 0 and `trap_sync` is 1.
- R8: For a taken synchronous or reset trap, `lreg0_val`/`lreg1_val` are `cur_pc`/`cur_npc`. For a taken asynchronous trap they are `cur_npc`/`cur_npc`+4.
- R9: An accepted asynchronous non-reset request with `st_et`=0 is dropped: `lreg_wr` stays 0, all outputs keep their values, and `trap_ready` stays 1.
- R10: An accepted synchronous non-reset request with `st_et`=0 sets `err_mode` to 1 and `trap_ready` to 0 from the next cycle. `lreg_wr` stays 0 and the other outputs keep their values. Error mode holds until `rst_n` is asserted.
- R11: On a taken trap, `new_pil` equals the `st_pil` value of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Trap request present |
| trap_ready | output | 1 | Block can accept a request (low in error mode) |
| trap_sync | input | 1 | 1 = synchronous trap, 0 = asynchronous |
| trap_is_reset | input | 1 | Request is a reset trap |
| trap_code | input | 8 | Trap-type code |
| st_et | input | 1 | Current trap-enable bit |
| st_s | input | 1 | Current supervisor bit |
| st_pil | input | 4 | Current interrupt level field |
| st_cwp | input | 3 | Current window pointer |
| cur_pc | input | 32 | Current PC |
| cur_npc | input | 32 | Current nPC |
| cur_tbr | input | 32 | Current trap base register |
| new_et | output | 1 | Trap-enable after entry |
| new_ps | output | 1 | Previous-supervisor after entry |
| new_pil | output | 4 | Interrupt level after entry |
| new_cwp | output | 3 | Trap window pointer |
| new_tbr | output | 32 | Trap base register with trap type merged |
| new_pc | output | 32 | Redirected PC |
| new_npc | output | 32 | Redirected nPC |
| lreg_wr | output | 1 | One-cycle write strobe for the trap window's first two locals; also the trap-taken pulse |
| lreg0_val | output | 32 | Value for the first local register |
| lreg1_val | output | 32 | Value for the second local register |
| err_mode | output | 1 | Sticky error mode |

## Verification
Two decisions can land on the same request. One is the reset-trap path, which always vectors. The other is the disabled-trap check, which sends a synchronous trap into error mode. Stimulus covers this with a reset request that also has `trap_sync`=1 and `st_et`=0. The bench passes only if `lreg_wr` pulses, `new_pc`/`new_npc` read 0/4 and `err_mode` stays 0. A second overlap comes from the window wrap (`st_cwp`=0) falling on a synchronous trap, where `new_cwp` and the saved pair are both judged in the same sample.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TAKE   = 2'd1,
    ACT_DROP   = 2'd2,
    ACT_ERROR  = 2'd3
  } trap_act_e;
endpackage

// File: rtl/trap_accept_ctl.sv
module trap_accept_ctl
  import trap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      req_sync,
  input  logic      req_reset,
  input  logic      cur_et,
  output logic      req_ready,
  output trap_act_e act,
  output logic      err_q
);
  logic fire;

  assign req_ready = ~err_q;
  assign fire      = req_valid & req_ready;

  always_comb begin
    act = ACT_NONE;
    if (fire) begin
      if (req_reset || cur_et) act = ACT_TAKE;
      else if (req_sync)       act = ACT_ERROR;
      else                     act = ACT_DROP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (act == ACT_ERROR) err_q <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R10
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_ERROR) |=> !req_ready); // R10
  AST_NO_FIRE_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (act == ACT_NONE)); // R1
endmodule

// File: rtl/trap_window_rot.sv
module trap_window_rot #(
  parameter int NWIN  = 8,
  parameter int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [CWP_W-1:0] cwp_in,
  output logic [CWP_W-1:0] cwp_dec
);
  localparam logic [CWP_W-1:0] TOP_WIN = CWP_W'(NWIN - 1);
  localparam bit POW2 = ((NWIN & (NWIN - 1)) == 0);

  generate
    if (POW2) begin : g_pow2
      assign cwp_dec = cwp_in - CWP_W'(1);
    end else begin : g_npow2
      assign cwp_dec = (cwp_in == '0) ? TOP_WIN : (cwp_in - CWP_W'(1));
    end
  endgenerate
endmodule

// File: rtl/trap_target_calc.sv
module trap_target_calc #(
  parameter int XLEN   = 32,
  parameter int TT_W   = 8,
  parameter int TT_LSB = 4
) (
  input  logic            is_sync,
  input  logic            is_reset,
  input  logic [TT_W-1:0] code,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] npc_in,
  input  logic [XLEN-1:0] tbr_in,
  output logic [XLEN-1:0] tbr_out,
  output logic [XLEN-1:0] pc_out,
  output logic [XLEN-1:0] npc_out,
  output logic [XLEN-1:0] ret0,
  output logic [XLEN-1:0] ret1
);
  localparam logic [XLEN-1:0] FIELD_ONES = XLEN'((64'd1 << TT_W) - 64'd1);
  localparam logic [XLEN-1:0] FIELD_MASK = FIELD_ONES << TT_LSB;
  localparam logic [XLEN-1:0] WORD       = XLEN'(4);

  logic [XLEN-1:0] code_shift;

  assign code_shift = XLEN'(code) << TT_LSB;
  assign tbr_out    = (tbr_in & ~FIELD_MASK) | code_shift;

  always_comb begin
    if (is_reset) begin
      pc_out  = '0;
      npc_out = WORD;
    end else begin
      pc_out  = tbr_out;
      npc_out = tbr_out + WORD;
    end
    if (is_sync || is_reset) begin
      ret0 = pc_in;
      ret1 = npc_in;
    end else begin
      ret0 = npc_in;
      ret1 = npc_in + WORD;
    end
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int XLEN   = 32,
  parameter int TT_W   = 8,
  parameter int TT_LSB = 4,
  parameter int PIL_W  = 4,
  parameter int CWP_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_valid,
  output logic             trap_ready,
  input  logic             trap_sync,
  input  logic             trap_is_reset,
  input  logic [TT_W-1:0]  trap_code,
  input  logic             st_et,
  input  logic             st_s,
  input  logic [PIL_W-1:0] st_pil,
  input  logic [CWP_W-1:0] st_cwp,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  cur_npc,
  input  logic [XLEN-1:0]  cur_tbr,
  output logic             new_et,
  output logic             new_ps,
  output logic [PIL_W-1:0] new_pil,
  output logic [CWP_W-1:0] new_cwp,
  output logic [XLEN-1:0]  new_tbr,
  output logic [XLEN-1:0]  new_pc,
  output logic [XLEN-1:0]  new_npc,
  output logic             lreg_wr,
  output logic [XLEN-1:0]  lreg0_val,
  output logic [XLEN-1:0]  lreg1_val,
  output logic             err_mode
);
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  trap_act_e        act;
  logic [CWP_W-1:0] cwp_next;
  logic [XLEN-1:0]  tbr_next, pc_next, npc_next, ret0_next, ret1_next;

  trap_accept_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (trap_valid),
    .req_sync  (trap_sync),
    .req_reset (trap_is_reset),
    .cur_et    (st_et),
    .req_ready (trap_ready),
    .act       (act),
    .err_q     (err_mode)
  );

  trap_window_rot #(.NWIN(NWIN), .CWP_W(CWP_W)) u_rot (
    .cwp_in  (st_cwp),
    .cwp_dec (cwp_next)
  );

  trap_target_calc #(.XLEN(XLEN), .TT_W(TT_W), .TT_LSB(TT_LSB)) u_tgt (
    .is_sync  (trap_sync),
    .is_reset (trap_is_reset),
    .code     (trap_code),
    .pc_in    (cur_pc),
    .npc_in   (cur_npc),
    .tbr_in   (cur_tbr),
    .tbr_out  (tbr_next),
    .pc_out   (pc_next),
    .npc_out  (npc_next),
    .ret0     (ret0_next),
    .ret1     (ret1_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lreg_wr   <= 1'b0;
      new_et    <= 1'b0;
      new_ps    <= 1'b0;
      new_pil   <= '0;
      new_cwp   <= '0;
      new_tbr   <= '0;
      new_pc    <= '0;
      new_npc   <= '0;
      lreg0_val <= '0;
      lreg1_val <= '0;
    end else begin
      lreg_wr <= (act == ACT_TAKE);
      if (act == ACT_TAKE) begin
        new_et    <= 1'b0;
        new_ps    <= st_s;
        new_pil   <= st_pil;
        new_cwp   <= cwp_next;
        new_tbr   <= tbr_next;
        new_pc    <= pc_next;
        new_npc   <= npc_next;
        lreg0_val <= ret0_next;
        lreg1_val <= ret1_next;
      end
    end
  end

  AST_ET_LOW_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    lreg_wr |-> !new_et); // R2
  AST_PS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    lreg_wr |-> (new_ps == $past(st_s))); // R3
  AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lreg_wr |-> (int'(new_cwp) < NWIN)); // R4
  AST_PC_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (lreg_wr && !$past(trap_is_reset)) |-> (new_pc == new_tbr)); // R6
  AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    lreg_wr |-> (new_npc == new_pc + WORD)); // R6
  AST_RESET_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (lreg_wr && $past(trap_is_reset)) |-> (new_pc == '0)); // R7
  AST_PIL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    lreg_wr |-> (new_pil == $past(st_pil))); // R11
  AST_ERR_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_mode) |-> (!lreg_wr && $stable(new_pc) && $stable(new_cwp))); // R10
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_DROP) |=> (!lreg_wr && $stable(new_tbr) && $stable(lreg0_val))); // R9
endmodule

// File: tb/sim_trap_entry_seq.sv
`timescale 1ns/1ps
module sim_trap_entry_seq;
  localparam int NV = 10;
  // {sync, is_reset, et, s, cwp[2:0], pil[3:0], code[7:0]}
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 4'd5,  8'h11},
    {1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 4'd0,  8'h02},
    {1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 4'd2,  8'h1A},
    {1'b1, 1'b1, 1'b0, 1'b1, 3'd7, 4'd15, 8'h00},
    {1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 4'd3,  8'h00},
    {1'b1, 1'b0, 1'b1, 1'b1, 3'd5, 4'd9,  8'hFF},
    {1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 4'd12, 8'h80},
    {1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 4'd1,  8'h1F},
    {1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 4'd7,  8'h09},
    {1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 4'd4,  8'h1C}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic trap_valid = 0, trap_sync = 0, trap_is_reset = 0, st_et = 0, st_s = 0;
  logic [7:0]  trap_code = '0;
  logic [3:0]  st_pil = '0;
  logic [2:0]  st_cwp = '0;
  logic [31:0] cur_pc = '0, cur_npc = '0, cur_tbr = '0;
  logic trap_ready, new_et, new_ps, lreg_wr, err_mode;
  logic [3:0]  new_pil;
  logic [2:0]  new_cwp;
  logic [31:0] new_tbr, new_pc, new_npc, lreg0_val, lreg1_val;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // shadow of expected registered outputs
  logic        e_ps;
  logic [3:0]  e_pil;
  logic [2:0]  e_cwp;
  logic [31:0] e_tbr, e_pc, e_npc, e_l0, e_l1;

  always #2 clk = ~clk;

  trap_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
    .trap_sync(trap_sync), .trap_is_reset(trap_is_reset), .trap_code(trap_code),
    .st_et(st_et), .st_s(st_s), .st_pil(st_pil), .st_cwp(st_cwp),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_tbr(cur_tbr),
    .new_et(new_et), .new_ps(new_ps), .new_pil(new_pil), .new_cwp(new_cwp),
    .new_tbr(new_tbr), .new_pc(new_pc), .new_npc(new_npc), .lreg_wr(lreg_wr),
    .lreg0_val(lreg0_val), .lreg1_val(lreg1_val), .err_mode(err_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic zero_shadow();
    e_ps = 0; e_pil = '0; e_cwp = '0; e_tbr = '0; e_pc = '0; e_npc = '0; e_l0 = '0; e_l1 = '0;
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " R3 new_ps"}, 32'(new_ps), 32'(e_ps));
    chk({tag, " R11 new_pil"}, 32'(new_pil), 32'(e_pil));
    chk({tag, " R4 new_cwp"}, 32'(new_cwp), 32'(e_cwp));
    chk({tag, " R5 new_tbr"}, new_tbr, e_tbr);
    chk({tag, " R6 new_pc"}, new_pc, e_pc);
    chk({tag, " R6 new_npc"}, new_npc, e_npc);
    chk({tag, " R8 lreg0"}, lreg0_val, e_l0);
    chk({tag, " R8 lreg1"}, lreg1_val, e_l1);
  endtask

  // drive at negedge, accept at posedge, sample at next negedge
  task automatic issue(input logic sy, input logic rs, input logic et, input logic s,
                       input logic [2:0] cwp, input logic [3:0] pil, input logic [7:0] code,
                       input logic [31:0] pc, input logic [31:0] tbr);
    trap_sync = sy; trap_is_reset = rs; st_et = et; st_s = s; st_cwp = cwp;
    st_pil = pil; trap_code = code; cur_pc = pc; cur_npc = pc + 32'd4; cur_tbr = tbr;
    trap_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    zero_shadow();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 trap_ready", 32'(trap_ready), 32'd1);
    chk("R1 err_mode", 32'(err_mode), 32'd0);
    chk("R1 lreg_wr", 32'(lreg_wr), 32'd0);
    chk("R1 new_et", 32'(new_et), 32'd0);
    check_outputs("R1");

    for (int i = 0; i < NV; i++) begin
      logic sy, rs, et, s;
      logic [2:0] cwp;
      logic [3:0] pil;
      logic [7:0] code;
      logic [31:0] pc, tbr, npc;
      bit take;
      {sy, rs, et, s, cwp, pil, code} = VEC[i];
      pc  = 32'h0000_4000 + 32'(i) * 32'h40;
      npc = pc + 32'd4;
      tbr = {20'h40000 + 20'(i), 8'hEE, 4'(i + 3)};
      take = rs || et;
      issue(sy, rs, et, s, cwp, pil, code, pc, tbr);
      if (take) begin
        e_ps  = s;
        e_pil = pil;
        e_cwp = (cwp == 3'd0) ? 3'd7 : cwp - 3'd1;
        e_tbr = {tbr[31:12], code, tbr[3:0]};
        e_pc  = rs ? 32'd0 : e_tbr;
        e_npc = rs ? 32'd4 : e_tbr + 32'd4;
        e_l0  = (sy || rs) ? pc  : npc;
        e_l1  = (sy || rs) ? npc : npc + 32'd4;
      end
      chk($sformatf("R2/R9 vec%0d lreg_wr", i), 32'(lreg_wr), 32'(take));
      chk($sformatf("R2 vec%0d new_et", i), 32'(new_et), 32'd0);
      chk($sformatf("R9 vec%0d ready", i), 32'(trap_ready), 32'd1);
      chk($sformatf("R7 vec%0d err_mode", i), 32'(err_mode), 32'd0);
      check_outputs($sformatf("vec%0d", i));
      // R2 pulse lasts one cycle
      @(negedge clk);
      chk($sformatf("R2 vec%0d pulse end", i), 32'(lreg_wr), 32'd0);
    end

    // R1 no accept while valid is low: outputs hold
    cur_tbr = 32'hFFFF_FFFF; st_et = 1'b1; trap_is_reset = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 idle lreg_wr", 32'(lreg_wr), 32'd0);
    check_outputs("R1 idle");

    // R10 sync trap with traps disabled
    issue(1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 4'd6, 8'h33, 32'h0000_9000, 32'h1234_5000);
    chk("R10 lreg_wr", 32'(lreg_wr), 32'd0);
    chk("R10 err_mode", 32'(err_mode), 32'd1);
    chk("R10 ready", 32'(trap_ready), 32'd0);
    check_outputs("R10 err");
    // R10 request held off in error mode
    issue(1'b0, 1'b0, 1'b1, 1'b0, 3'd5, 4'd2, 8'h44, 32'h0000_A000, 32'h2222_2000);
    chk("R10 blocked lreg_wr", 32'(lreg_wr), 32'd0);
    chk("R10 sticky", 32'(err_mode), 32'd1);
    check_outputs("R10 blocked");

    // R10/R1 only rst_n clears
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    zero_shadow();
    chk("R10 cleared", 32'(err_mode), 32'd0);
    chk("R1 ready again", 32'(trap_ready), 32'd1);
    check_outputs("R1 after reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule